// File: doc/BRIEF.md
# IRQ8 Line Arbiter

This block decides which interrupt source owns the internal line 8 that feeds the legacy interrupt controller and the advanced interrupt controller together. It has three kinds of input: the real-time clock interrupt request, the line-8 slot recovered from a serial interrupt stream, and the requests of `NUM_TIMERS` event timers. Each timer has a routing field that a small write port programs.

The serial-stream slot is always discarded. The RTC keeps the line as long as no timer is routed to line 8. Once any timer selects line 8, the timers take the line. Their requests are OR-ed onto it, and the RTC request is reported as blocked.

Ownership is held by a two-state machine. `OWNER_RTC` is the state after reset. The **claim** transition goes to `OWNER_TIMER` on any edge where at least one routing field holds 8. The **release** transition goes back to `OWNER_RTC` on any edge where no field holds 8. Both the line and the blocked flag are registered outputs of this machine.

Top module: `irq8_line_arbiter`

## Requirements
- R1: `irq8_legacy_o` and `irq8_adv_o` always carry the same value.
- R2: When no routing field holds 8, the line takes the value `rtc_req` had at the previous clock edge.
- R3: `serial_irq8` never has any effect on either line output or on `rtc_blocked_o`.
- R4: When one or more routing fields hold 8, the line takes, one edge later, the OR of the requests of those timers only. In that case `rtc_req` has no effect on the line.
- R5: `rtc_blocked_o` goes high one edge after an edge where `rtc_req` is 1 and some routing field holds 8. Otherwise it is low.
- R6: A routing field holding any value other than 8 (for example 0, 7, 9 or 31) leaves that timer's request off the line and leaves the RTC in control.
- R7: A write with `cfg_we`=1 and `cfg_idx` < `NUM_TIMERS` stores the 5-bit `cfg_route` into that timer's field at the clock edge. The line reflects the new routing from the following edge. A write with `cfg_idx` >= `NUM_TIMERS` changes no field.
- R8: While `rst_n` is low, both line outputs and `rtc_blocked_o` are 0, every routing field is 0, and the owner is `OWNER_RTC`.
- R9: While the requests and the routing stay unchanged, the line output holds its value without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_req | input | 1 | Real-time clock interrupt request |
| serial_irq8 | input | 1 | Line-8 slot from the serial interrupt stream (discarded) |
| tmr_req | input | NUM_TIMERS | Event-timer interrupt requests |
| cfg_we | input | 1 | Routing write enable |
| cfg_idx | input | IDX_W | Timer index for the routing write |
| cfg_route | input | ROUTE_W | Routing value to store |
| irq8_legacy_o | output | 1 | Line 8 to the legacy controller |
| irq8_adv_o | output | 1 | Line 8 to the advanced controller |
| rtc_blocked_o | output | 1 | RTC request present but masked by timer ownership |

## Verification
The assertions check the following on every cycle: the RTC following the line when no timer is routed, the serial slot never raising the line, the claim into `OWNER_TIMER`, the blocked flag in both directions, field storage after each write, and the line staying stable under stable inputs. Some behaviour can only be shown by the bench scenarios. These include the OR across several routed timers, the release back to the RTC after reprogramming, writes to out-of-range indices, the non-8 route values, and the two outputs agreeing under every pattern.

// File: rtl/irq8_arb_pkg.sv
package irq8_arb_pkg;
    typedef enum logic {
        OWNER_RTC   = 1'b0,
        OWNER_TIMER = 1'b1
    } owner_e;
endpackage

// File: rtl/irq8_route_regs.sv
module irq8_route_regs #(
    parameter int NUM_TIMERS = 3,
    parameter int ROUTE_W    = 5,
    parameter int TARGET     = 8,
    parameter int IDX_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [ROUTE_W-1:0]    wr_val,
    output logic [NUM_TIMERS-1:0] hit
);
    localparam logic [ROUTE_W-1:0] TARGET_CODE = ROUTE_W'(TARGET);

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_field
        logic [ROUTE_W-1:0] route_q;
        logic               sel;

        assign sel = wr_en && (int'(wr_idx) == i);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                route_q <= '0;
            end else if (sel) begin
                route_q <= wr_val;
            end
        end

        assign hit[i] = (route_q == TARGET_CODE);

        // R7: a write to this field decides its hit from the next edge
        p_write_stores_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && int'(wr_idx) == i) |=> (hit[i] == ($past(wr_val) == TARGET_CODE)));
    end
endmodule

// File: rtl/irq8_timer_merge.sv
module irq8_timer_merge #(
    parameter int NUM_TIMERS = 3
) (
    input  logic [NUM_TIMERS-1:0] req,
    input  logic [NUM_TIMERS-1:0] hit,
    output logic                  any_hit,
    output logic                  timer_line
);
    assign any_hit    = |hit;
    assign timer_line = |(req & hit);
endmodule

// File: rtl/irq8_owner_fsm.sv
module irq8_owner_fsm
    import irq8_arb_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   any_hit,
    input  logic   timer_line,
    input  logic   rtc_req,
    output logic   line_q,
    output logic   blocked_q,
    output owner_e owner
);
    owner_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OWNER_RTC:   if (any_hit)  state_d = OWNER_TIMER;  // claim
            OWNER_TIMER: if (!any_hit) state_d = OWNER_RTC;    // release
            default:     state_d = OWNER_RTC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OWNER_RTC;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q    <= 1'b0;
            blocked_q <= 1'b0;
        end else begin
            unique case (state_d)
                OWNER_RTC: begin
                    line_q    <= rtc_req;
                    blocked_q <= 1'b0;
                end
                OWNER_TIMER: begin
                    line_q    <= timer_line;
                    blocked_q <= rtc_req;
                end
                default: begin
                    line_q    <= 1'b0;
                    blocked_q <= 1'b0;
                end
            endcase
        end
    end

    assign owner = state_q;

    // R4: a routed timer puts the machine into timer ownership
    p_claim_r4: assert property (@(posedge clk) disable iff (!rst_n)
        any_hit |=> (owner == OWNER_TIMER));
    // R5: blocked only while a timer owns the line
    p_block_needs_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
        blocked_q |-> (owner == OWNER_TIMER));
endmodule

// File: rtl/irq8_line_arbiter.sv
module irq8_line_arbiter
    import irq8_arb_pkg::*;
#(
    parameter int NUM_TIMERS = 3,
    parameter int ROUTE_W    = 5,
    parameter int TARGET     = 8,
    parameter int IDX_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rtc_req,
    input  logic                  serial_irq8,
    input  logic [NUM_TIMERS-1:0] tmr_req,
    input  logic                  cfg_we,
    input  logic [IDX_W-1:0]      cfg_idx,
    input  logic [ROUTE_W-1:0]    cfg_route,
    output logic                  irq8_legacy_o,
    output logic                  irq8_adv_o,
    output logic                  rtc_blocked_o
);
    logic [NUM_TIMERS-1:0] hit;
    logic                  any_hit;
    logic                  timer_line;
    logic                  line_q;
    owner_e                owner;
    logic [1:0]            warm_q;

    irq8_route_regs #(
        .NUM_TIMERS (NUM_TIMERS),
        .ROUTE_W    (ROUTE_W),
        .TARGET     (TARGET),
        .IDX_W      (IDX_W)
    ) u_routes (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_idx (cfg_idx),
        .wr_val (cfg_route),
        .hit    (hit)
    );

    irq8_timer_merge #(
        .NUM_TIMERS (NUM_TIMERS)
    ) u_merge (
        .req        (tmr_req),
        .hit        (hit),
        .any_hit    (any_hit),
        .timer_line (timer_line)
    );

    irq8_owner_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .any_hit    (any_hit),
        .timer_line (timer_line),
        .rtc_req    (rtc_req),
        .line_q     (line_q),
        .blocked_q  (rtc_blocked_o),
        .owner      (owner)
    );

    // one register fans out to both controllers
    assign irq8_legacy_o = line_q;
    assign irq8_adv_o    = line_q;

    // edges seen since reset, saturating; used to gate history-based checks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R2: RTC drives the line while nothing is routed
    p_rtc_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> (irq8_legacy_o == $past(rtc_req)));
    // R3: the serial slot alone never raises the line
    p_serial_dropped_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (serial_irq8 && !rtc_req && !any_hit) |=> !irq8_adv_o);
    // R5: masked RTC request is reported
    p_blocked_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (any_hit && rtc_req) |=> rtc_blocked_o);
    p_blocked_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !any_hit |=> !rtc_blocked_o);
    // R9: unchanged requests and routing give an unchanged line
    p_no_glitch_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $stable(rtc_req) && $stable(tmr_req) && $stable(hit))
        |=> $stable(irq8_legacy_o));
endmodule

// File: tb/sim_irq8_line_arbiter.sv
module sim_irq8_line_arbiter;
    localparam int N  = 3;
    localparam int RW = 5;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          rtc_req, serial_irq8, cfg_we;
    logic [N-1:0]  tmr_req;
    logic [IW-1:0] cfg_idx;
    logic [RW-1:0] cfg_route;
    logic          irq8_legacy_o, irq8_adv_o, rtc_blocked_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [RW-1:0] model_route [N];

    always #5 clk = ~clk;

    irq8_line_arbiter #(.NUM_TIMERS(N), .ROUTE_W(RW), .TARGET(8), .IDX_W(IW)) u0 (
        .clk, .rst_n, .rtc_req, .serial_irq8, .tmr_req, .cfg_we, .cfg_idx,
        .cfg_route, .irq8_legacy_o, .irq8_adv_o, .rtc_blocked_o
    );

    task automatic chk(string req, logic got, logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    function automatic logic any_routed();
        for (int i = 0; i < N; i++) if (model_route[i] == 5'd8) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic exp_line(logic r, logic [N-1:0] t);
        logic l = 1'b0;
        for (int i = 0; i < N; i++) if (model_route[i] == 5'd8) l |= t[i];
        return any_routed() ? l : r;
    endfunction

    // apply inputs, clock once, compare both lines and the blocked flag
    task automatic apply(string req, logic r, logic s, logic [N-1:0] t);
        logic el, eb;
        rtc_req = r; serial_irq8 = s; tmr_req = t;
        el = exp_line(r, t);
        eb = r && any_routed();
        step();
        chk({req, " line"}, irq8_legacy_o, el);
        chk("R1 outputs agree", irq8_adv_o, irq8_legacy_o);
        chk({req, " blocked"}, rtc_blocked_o, eb);
    endtask

    task automatic write_route(int idx, logic [RW-1:0] v);
        cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_route = v;
        step();
        cfg_we = 1'b0;
        if (idx < N) model_route[idx] = v;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; rtc_req = 1'b1; serial_irq8 = 1'b1; tmr_req = '1;
        cfg_we = 1'b0; cfg_idx = '0; cfg_route = '0;
        for (int i = 0; i < N; i++) model_route[i] = '0;
        step(); step();
        chk("R8 reset legacy", irq8_legacy_o, 1'b0);
        chk("R8 reset adv", irq8_adv_o, 1'b0);
        chk("R8 reset blocked", rtc_blocked_o, 1'b0);
        rst_n = 1'b1;
        // routes reset to 0, so the RTC owns the line
        apply("R8 R2 post-reset owner", 1'b1, 1'b0, '1);
    endtask

    task automatic t_rtc_follow();
        apply("R2 rtc low", 1'b0, 1'b0, 3'b101);
        apply("R2 rtc high", 1'b1, 1'b0, 3'b000);
        apply("R2 rtc low again", 1'b0, 1'b0, 3'b111);
    endtask

    task automatic t_serial_ignored();
        apply("R3 serial alone", 1'b0, 1'b1, 3'b000);
        apply("R3 serial with rtc", 1'b1, 1'b1, 3'b000);
        apply("R3 serial drop", 1'b0, 1'b1, 3'b000);
    endtask

    task automatic t_non8_routes();
        write_route(0, 5'd7);
        write_route(1, 5'd9);
        write_route(2, 5'd31);
        apply("R6 non-8 routes rtc low", 1'b0, 1'b0, 3'b111);
        apply("R6 non-8 routes rtc high", 1'b1, 1'b0, 3'b111);
    endtask

    task automatic t_timer_owns();
        write_route(1, 5'd8);
        apply("R4 R5 timer1 low, rtc high", 1'b1, 1'b0, 3'b101);
        apply("R4 timer1 high", 1'b0, 1'b0, 3'b010);
        apply("R4 R3 serial under timer", 1'b0, 1'b1, 3'b000);
        write_route(2, 5'd8);
        apply("R4 timer2 only", 1'b1, 1'b0, 3'b100);
        apply("R4 both routed low", 1'b1, 1'b0, 3'b001);
        apply("R4 both high", 1'b0, 1'b0, 3'b110);
    endtask

    task automatic t_bad_index();
        write_route(3, 5'd0);
        apply("R7 bad index keeps route", 1'b1, 1'b0, 3'b010);
        write_route(1, 5'd0);
        write_route(2, 5'd3);
        apply("R7 R5 release to rtc", 1'b1, 1'b0, 3'b110);
        write_route(3, 5'd8);
        apply("R7 bad index no claim", 1'b0, 1'b0, 3'b111);
    endtask

    task automatic t_write_timing();
        rtc_req = 1'b1; tmr_req = 3'b000;
        // the write edge itself still uses the old routing
        cfg_we = 1'b1; cfg_idx = 2'd0; cfg_route = 5'd8;
        step();
        cfg_we = 1'b0;
        chk("R7 write edge uses old routing", irq8_legacy_o, 1'b1);
        model_route[0] = 5'd8;
        apply("R7 next edge uses new routing", 1'b1, 1'b0, 3'b000);
    endtask

    task automatic t_glitch();
        logic first;
        rtc_req = 1'b0; tmr_req = 3'b001; serial_irq8 = 1'b0;
        step();
        first = irq8_legacy_o;
        chk("R9 held line value", first, 1'b1);
        for (int k = 0; k < 6; k++) begin
            #2 chk("R9 stable mid-cycle", irq8_legacy_o, first);
            serial_irq8 = ~serial_irq8;
            step();
            chk("R9 stable after edge", irq8_legacy_o, first);
        end
    endtask

    initial begin
        t_reset();
        t_rtc_follow();
        t_serial_ignored();
        t_non8_routes();
        t_timer_owns();
        t_bad_index();
        t_write_timing();
        t_glitch();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired before the scenarios ended");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule